// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns a single serial bit stream, one bit per clock, into parallel words. Each clock it takes one bit from one of two serial inputs. A select line chooses the input, so the second input can act as a loopback path during link testing. Every fourth clock (narrow mode) or every eighth clock (wide mode) the collected bits are transferred to a parallel output register.

The block also re-drives the chosen serial bit, one clock later, on a serial output. A second instance can then sit behind the first to build a 1:8 converter. Two divided clock outputs come from the word counter. One runs at a quarter of the clock rate and one at an eighth, so downstream logic can follow the word rate.

Word alignment can be corrected at run time. Each rising edge on the slip request input holds the word counter for one clock. This moves the word boundary one bit later in the stream.

Top module: `sdes_slip_deser`

## Requirements
- R1: Bit order: within a loaded word, the earliest received bit sits on `par_q[0]` and the latest on `par_q[3]`.
- R2: Input select: `sel_a` = 1 takes bits from `sin_a`, and `sel_a` = 0 takes bits from `sin_b`. The other input has no effect on the captured data.
- R3: In narrow mode (`mode_wide` = 0), `par_q` reloads on every fourth clock and holds its value in between. `load_stb` is high for exactly the one clock cycle after each reload.
- R4: In wide mode (`mode_wide` = 1), `par_q` reloads on every eighth clock only. The loaded word holds the last four of those eight bits, and `load_stb` stays low on the fourth clock.
- R5: `word_clk` is low for two clocks and then high for two clocks, starting low after reset. It is low whenever `load_stb` is high.
- R6: `pair_clk` is low for four clocks and then high for four clocks, starting low after reset.
- R7: `ser_out` shows the selected serial bit one clock after that bit is sampled. On each reload, `par_q[3]` equals `ser_out`.
- R8: A rising edge on `slip_req`, held for at least two clocks, holds the word counter for one clock. The bit that appeared on `par_q[n]` then appears on `par_q[n-1]`, and the old `par_q[0]` bit moves to `par_q[3]` of the word before.
- R9: Holding `slip_req` high gives only one slip. Each further rising edge gives one further slip.
- R10: While `rst_n` is low on a clock edge, the following are cleared: `par_q`, `ser_out`, `load_stb`, `word_clk` and `pair_clk`. After release, the first word is the first four bits sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sin_a | input | 1 | Serial input A |
| sin_b | input | 1 | Serial input B (loopback) |
| sel_a | input | 1 | 1 selects `sin_a`, 0 selects `sin_b` |
| mode_wide | input | 1 | 0: reload every 4 clocks, 1: every 8 clocks |
| slip_req | input | 1 | Asynchronous slip request, rising-edge counted |
| par_q | output | 4 | Parallel word |
| ser_out | output | 1 | Selected serial bit delayed one clock |
| word_clk | output | 1 | Clock divided by 4 |
| pair_clk | output | 1 | Clock divided by 8 |
| load_stb | output | 1 | One-cycle pulse after each reload |

## Verification
The bench drives inputs 1 ns after a rising edge, so each bit is sampled at the next edge, and it reads the outputs 1 ns after that edge. `ser_out`, `word_clk` and `pair_clk` are checked after every edge, because each updates on the edge that samples the bit. `par_q` and `load_stb` are due on the edge that samples the fourth bit (narrow mode) or the eighth bit (wide mode), counted from reset release. A slip request takes effect on the third edge after it rises, which the bench cannot easily pin to a cycle. The slip checks therefore use a periodic stream and read `par_q` only after at least eight further clocks, when the shifted alignment has settled.

// File: rtl/sdes_pkg.sv
// Shared definitions for the slip deserializer.
// Assumes: nothing beyond IEEE 1800-2017.
package sdes_pkg;
    typedef enum logic {
        WIDTH_NARROW = 1'b0,
        WIDTH_WIDE   = 1'b1
    } width_mode_e;

    // Number of bits needed to count one word.
    function automatic int unsigned word_bits(input int unsigned w);
        return (w <= 1) ? 1 : $clog2(w);
    endfunction
endpackage

// File: rtl/sdes_slip_sync.sv
// Brings the asynchronous slip request into the clock domain through
// STAGES flops and emits a one-cycle pulse per rising edge.
// Assumes: the request is held for at least two clocks.
module sdes_slip_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic slip_pulse
);
    logic [STAGES:0] chain_r;

    // Shift the request through the synchronizer plus one edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_r <= '0;
        else        chain_r <= {chain_r[STAGES-1:0], req_async};
    end

    assign slip_pulse = chain_r[STAGES-1] & ~chain_r[STAGES];

    // A held request must never give two pulses in a row.
    p_slip_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slip_pulse |=> !slip_pulse);
endmodule

// File: rtl/sdes_divider.sv
// Word counter: counts bit clocks, is held for one clock per slip pulse,
// picks the reload cycle by mode, and drives the divided clock outputs.
// Assumes: WORD_W is a power of two, at least 2.
module sdes_divider
    import sdes_pkg::*;
#(
    parameter int unsigned WORD_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  width_mode_e mode,
    input  logic        slip,
    output logic        load_now,
    output logic        load_stb,
    output logic        word_clk,
    output logic        pair_clk
);
    localparam int unsigned LOW_W = word_bits(WORD_W);
    localparam int unsigned CNT_W = LOW_W + 1;

    logic [CNT_W-1:0] cnt_r;
    logic             term;

    // End of a word interval for the chosen mode.
    always_comb begin
        if (mode == WIDTH_WIDE) term = &cnt_r;
        else                    term = &cnt_r[LOW_W-1:0];
    end

    // A reload happens only on a counting clock, so a slip delays it by one.
    assign load_now = term & ~slip;

    // Advance the counter unless a slip pulse swallows this count.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_r <= '0;
        else if (!slip) cnt_r <= cnt_r + 1'b1;
    end

    // Register the reload strobe so it lines up with the parallel output.
    always_ff @(posedge clk) begin
        if (!rst_n) load_stb <= 1'b0;
        else        load_stb <= load_now;
    end

    assign word_clk = cnt_r[LOW_W-1];
    assign pair_clk = cnt_r[CNT_W-1];

    // Reloads never come on two clocks in a row.
    p_load_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);
    // Right after a reload the quarter-rate clock is in its low half.
    p_word_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> !word_clk);
endmodule

// File: rtl/sdes_shift_path.sv
// Input select, shift register, serial retime flop and parallel register.
// Assumes: load_now is high for single cycles only.
module sdes_shift_path #(
    parameter int unsigned WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sin_a,
    input  logic              sin_b,
    input  logic              sel_a,
    input  logic              load_now,
    output logic [WORD_W-1:0] par_q,
    output logic              ser_out
);
    logic              bit_in;
    logic [WORD_W-1:0] shift_r;
    logic [WORD_W-1:0] word_next;

    assign bit_in    = sel_a ? sin_a : sin_b;
    // The newest bit enters at the top, so the oldest ends at bit 0.
    assign word_next = {bit_in, shift_r[WORD_W-1:1]};

    // Collect serial bits.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_r <= '0;
        else        shift_r <= word_next;
    end

    // Retime the selected bit for the cascade output.
    always_ff @(posedge clk) begin
        if (!rst_n) ser_out <= 1'b0;
        else        ser_out <= bit_in;
    end

    // Transfer the completed word, including the bit sampled on this clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        par_q <= '0;
        else if (load_now) par_q <= word_next;
    end
endmodule

// File: rtl/sdes_slip_deser.sv
// Top level of the 1:4 deserializer with bit slip and cascade output.
// Assumes: one clock domain; slip_req may be asynchronous.
module sdes_slip_deser
    import sdes_pkg::*;
#(
    parameter int unsigned WORD_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sin_a,
    input  logic              sin_b,
    input  logic              sel_a,
    input  logic              mode_wide,
    input  logic              slip_req,
    output logic [WORD_W-1:0] par_q,
    output logic              ser_out,
    output logic              word_clk,
    output logic              pair_clk,
    output logic              load_stb
);
    logic        slip_pulse;
    logic        load_now;
    width_mode_e mode;

    assign mode = width_mode_e'(mode_wide);

    sdes_slip_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_async  (slip_req),
        .slip_pulse (slip_pulse)
    );

    sdes_divider #(.WORD_W(WORD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .slip     (slip_pulse),
        .load_now (load_now),
        .load_stb (load_stb),
        .word_clk (word_clk),
        .pair_clk (pair_clk)
    );

    sdes_shift_path #(.WORD_W(WORD_W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .sin_a    (sin_a),
        .sin_b    (sin_b),
        .sel_a    (sel_a),
        .load_now (load_now),
        .par_q    (par_q),
        .ser_out  (ser_out)
    );

    // The newest bit of a reloaded word is the bit just retimed out.
    p_last_bit_ser_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (par_q[WORD_W-1] == ser_out));
    // The parallel word changes only together with the reload strobe.
    p_par_only_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(par_q) |-> load_stb);
endmodule

// File: tb/sim_sdes_slip_deser.sv
module sim_sdes_slip_deser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sin_a = 1'b0;
    logic       sin_b = 1'b0;
    logic       sel_a = 1'b1;
    logic       mode_wide = 1'b0;
    logic       slip_req = 1'b0;
    logic [3:0] par_q;
    logic       ser_out, word_clk, pair_clk, load_stb;

    int checks = 0;
    int fails  = 0;
    int n      = 0;   // edges since reset release

    always #2.5 clk = ~clk;

    sdes_slip_deser u0 (
        .clk(clk), .rst_n(rst_n), .sin_a(sin_a), .sin_b(sin_b), .sel_a(sel_a),
        .mode_wide(mode_wide), .slip_req(slip_req), .par_q(par_q),
        .ser_out(ser_out), .word_clk(word_clk), .pair_clk(pair_clk),
        .load_stb(load_stb)
    );

    // {select, word}; the word is sent bit 0 first.
    localparam logic [4:0] VEC [0:7] = '{
        5'b1_0001, 5'b0_1000, 5'b1_1010, 5'b0_0101,
        5'b1_1111, 5'b0_0000, 5'b1_0110, 5'b0_1001
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Put a bit on the selected input (its inverse on the other) and clock it in.
    task automatic drive(input logic b, input logic s);
        sel_a = s;
        if (s) begin sin_a = b; sin_b = ~b; end
        else   begin sin_b = b; sin_a = ~b; end
        @(posedge clk); #1;
        n++;
    endtask

    task automatic do_reset(input logic wide);
        rst_n = 1'b0; mode_wide = wide; slip_req = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        n = 0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] held;
        logic [7:0] wd;
        // R10: reset state
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R10 par", {4'h0, par_q}, 8'h00);
        chk("R10 ser", {7'h0, ser_out}, 8'h00);
        chk("R10 strobes", {5'h0, word_clk, pair_clk, load_stb}, 8'h00);
        rst_n = 1'b1;
        n = 0;

        // Table walk in narrow mode: R1 R2 R3 R5 R6 R7 R10
        held = 4'h0;
        for (int v = 0; v < 8; v++) begin
            for (int b = 0; b < 4; b++) begin
                drive(VEC[v][b], VEC[v][4]);
                chk("R7 ser_out", {7'h0, ser_out}, {7'h0, VEC[v][b]});
                chk("R5 word_clk", {7'h0, word_clk}, {7'h0, logic'((n % 4) >= 2)});
                chk("R6 pair_clk", {7'h0, pair_clk}, {7'h0, logic'((n % 8) >= 4)});
                if (b == 3) begin
                    chk("R1 R2 par", {4'h0, par_q}, {4'h0, VEC[v][3:0]});
                    chk("R3 load_stb high", {7'h0, load_stb}, 8'h01);
                    held = VEC[v][3:0];
                end else begin
                    chk("R3 par held", {4'h0, par_q}, {4'h0, held});
                    chk("R3 load_stb low", {7'h0, load_stb}, 8'h00);
                end
            end
        end

        // R10: reset in mid-run
        drive(1'b1, 1'b1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R10 mid par", {4'h0, par_q}, 8'h00);
        chk("R10 mid ser", {7'h0, ser_out}, 8'h00);
        chk("R10 mid strobes", {5'h0, word_clk, pair_clk, load_stb}, 8'h00);

        // R4 R6: wide mode, eight bits per reload
        do_reset(1'b1);
        wd = 8'b1011_0010;
        for (int b = 0; b < 8; b++) begin
            drive(wd[b], 1'b1);
            if (b == 3) begin
                chk("R4 no reload at 4", {4'h0, par_q}, 8'h00);
                chk("R4 no strobe at 4", {7'h0, load_stb}, 8'h00);
                chk("R6 pair_clk high", {7'h0, pair_clk}, 8'h01);
            end
        end
        chk("R4 wide word", {4'h0, par_q}, {4'h0, wd[7:4]});
        chk("R4 wide strobe", {7'h0, load_stb}, 8'h01);
        chk("R6 pair_clk low", {7'h0, pair_clk}, 8'h00);

        // R8 R9: periodic stream 1,0,0,0 on input B
        do_reset(1'b0);
        for (int k = 0; k < 8; k++) drive(logic'((k % 4) == 0), 1'b0);
        chk("R8 aligned", {4'h0, par_q}, 8'h01);
        slip_req = 1'b1;
        for (int k = 0; k < 10; k++) drive(logic'((k % 4) == 0), 1'b0);
        slip_req = 1'b0;
        for (int k = 0; k < 8; k++) drive(logic'((k % 4) == 2), 1'b0);
        chk("R8 R9 one slip while held", {4'h0, par_q}, 8'h08);
        slip_req = 1'b1;
        for (int k = 0; k < 3; k++) drive(logic'((k % 4) == 2), 1'b0);
        slip_req = 1'b0;
        for (int k = 3; k < 15; k++) drive(logic'((k % 4) == 2), 1'b0);
        chk("R9 second slip", {4'h0, par_q}, 8'h04);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule